// File: doc/BRIEF.md
# CBC Chaining Stage for a 128-bit Block Cipher

This block sits between a block source, a separate 128-bit block cipher core and a block sink. It turns the cipher core's single-block transform into cipher block chaining in either direction. It keeps a chaining register. In encryption it mixes each plaintext block into the chain before the core. In decryption it mixes the core's result with the chain after the core. After every block it refreshes the chain with the correct ciphertext block.

Work is organised in commands. A command starts with a start pulse that carries a direction and a continue flag. It ends with the block marked as last. With continue clear, the chain is seeded from the most recently loaded initialisation vector. With continue set, the chain left by the previous command carries over and any loaded vector is disregarded. One long message can therefore be cut into several commands, and the result matches a single command over the whole message. Exactly one block is in flight at a time. Every handshake is valid/ready, and back-pressure at any point stalls the stage without losing or repeating a chain update.

Top module: `cbc_chain_unit`

## Requirements
- R1: A synchronous active-high reset clears the chain and the vector holding register to zero and leaves the stage idle: cmd_ready high, and in_ready, cph_req_valid and out_valid low. A command started with continue set right after reset chains from zero.
- R2: A start with cmd_continue low seeds the chain from the vector written by the latest iv_load pulse in an earlier cycle. Earlier loads are overwritten.
- R3: In encryption (cmd_decrypt low) the core receives the plaintext XOR the chain. The output block is the core's result unchanged, and the chain becomes that result.
- R4: In decryption (cmd_decrypt high) the core receives the input block unchanged. The output is the core's result XOR the chain, and the chain becomes the input block that was consumed. cph_req_decrypt repeats the command's direction.
- R5: A start with cmd_continue high keeps the chain left by the previous command and ignores any vector loaded since. An encryption split into two such commands produces the same blocks as one command.
- R6: After a decryption command the chain equals the last ciphertext block consumed. It is not the last block produced, so a continued decryption of the rest of a message matches the unsplit result.
- R7: While out_valid is high and out_ready low, out_data and out_last hold steady and no new input block is accepted (in_ready low).
- R8: While cph_req_valid is high and cph_req_ready low, cph_req_data holds steady.
- R9: out_last is high on the output of the block that arrived with in_last. Once that output is taken, the command ends and cmd_ready returns high.
- R10: A cmd_start pulse while cmd_ready is low is ignored. It changes neither the direction nor the chain of the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iv_load | input | 1 | Write iv_data into the vector holding register |
| iv_data | input | 128 | Initialisation vector |
| cmd_start | input | 1 | Start a command (taken only while cmd_ready) |
| cmd_decrypt | input | 1 | Direction of the command: 1 decrypt, 0 encrypt |
| cmd_continue | input | 1 | 1: keep the chain from the previous command; 0: seed from the vector |
| cmd_ready | output | 1 | Stage idle, ready for a start |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Stage accepts an input block |
| in_data | input | 128 | Input block (plaintext or ciphertext) |
| in_last | input | 1 | Input block is the last of the command |
| cph_req_valid | output | 1 | Block offered to the cipher core |
| cph_req_ready | input | 1 | Cipher core takes the block |
| cph_req_data | output | 128 | Block for the cipher core |
| cph_req_decrypt | output | 1 | Direction for the cipher core |
| cph_rsp_valid | input | 1 | Cipher core result valid |
| cph_rsp_ready | output | 1 | Stage takes the core's result |
| cph_rsp_data | input | 128 | Cipher core result |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Sink takes the output block |
| out_data | output | 128 | Output block |
| out_last | output | 1 | Output block ends the command |

## Verification
A corrupted chain shows only at the next block. In encryption it appears at the cipher request of that next block. In decryption it appears at the output of that next block, while the request still looks right. A wrong carry-over between commands therefore surfaces at the first block of the continued command. The bench compares every cipher request and every output block against a reference chain model, and runs split messages against their unsplit results. Handshake faults show within one cycle of a stall as a changed held value or a premature in_ready.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    // Sequencing of one block through the stage
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,   // waiting for a command start
        ST_TAKE    = 3'd1,   // waiting for an input block
        ST_ISSUE   = 3'd2,   // offering the block to the cipher core
        ST_AWAIT   = 3'd3,   // waiting for the core's result
        ST_DELIVER = 3'd4    // holding the output block for the sink
    } step_e;

    // Flags latched for the running command / block
    typedef struct packed {
        logic dec;    // command direction
        logic last;   // block in flight closes the command
    } flags_t;

    localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/cbc_seq.sv
module cbc_seq
    import cbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_start,
    input  logic cmd_decrypt,
    input  logic in_valid,
    input  logic in_last,
    input  logic cph_req_ready,
    input  logic cph_rsp_valid,
    input  logic out_ready,
    output logic cmd_ready,
    output logic in_ready,
    output logic cph_req_valid,
    output logic cph_rsp_ready,
    output logic out_valid,
    output logic out_last,
    output logic start_fire,
    output logic take_fire,
    output logic rsp_fire,
    output logic mode_dec
);

    step_e  step_q;
    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            flags_q <= '0;
        end else begin
            unique case (step_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        flags_q.dec <= cmd_decrypt;
                        step_q      <= ST_TAKE;
                    end
                end
                ST_TAKE: begin
                    if (in_valid) begin
                        flags_q.last <= in_last;
                        step_q       <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cph_req_ready) step_q <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (cph_rsp_valid) step_q <= ST_DELIVER;
                end
                ST_DELIVER: begin
                    if (out_ready) step_q <= flags_q.last ? ST_IDLE : ST_TAKE;
                end
                default: step_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_ready     = (step_q == ST_IDLE);
        in_ready      = (step_q == ST_TAKE);
        cph_req_valid = (step_q == ST_ISSUE);
        cph_rsp_ready = (step_q == ST_AWAIT);
        out_valid     = (step_q == ST_DELIVER);
        out_last      = out_valid & flags_q.last;
        start_fire    = cmd_ready & cmd_start;
        take_fire     = in_ready & in_valid;
        rsp_fire      = cph_rsp_ready & cph_rsp_valid;
        mode_dec      = flags_q.dec;
    end

endmodule

// File: rtl/cbc_chain_store.sv
module cbc_chain_store #(
    parameter int unsigned BLOCK_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               iv_load,
    input  logic [BLOCK_W-1:0] iv_data,
    input  logic               start_fire,
    input  logic               start_cont,
    input  logic               upd_en,
    input  logic [BLOCK_W-1:0] upd_val,
    output logic [BLOCK_W-1:0] chain_q
);

    logic [BLOCK_W-1:0] iv_q;

    // Latest vector written; used only by a fresh start
    always_ff @(posedge clk) begin
        if (rst)          iv_q <= '0;
        else if (iv_load) iv_q <= iv_data;
    end

    // Chain: seeded on a fresh start, refreshed once per block,
    // untouched by a continued start
    always_ff @(posedge clk) begin
        if (rst)                            chain_q <= '0;
        else if (start_fire && !start_cont) chain_q <= iv_q;
        else if (upd_en)                    chain_q <= upd_val;
    end

endmodule

// File: rtl/cbc_xfer.sv
module cbc_xfer
    import cbc_pkg::*;
#(
    parameter int unsigned BLOCK_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_dec,
    input  logic               take_fire,
    input  logic [BLOCK_W-1:0] in_data,
    input  logic [BLOCK_W-1:0] chain_q,
    input  logic               rsp_fire,
    input  logic [BLOCK_W-1:0] rsp_data,
    output logic [BLOCK_W-1:0] req_q,
    output logic [BLOCK_W-1:0] out_q,
    output logic [BLOCK_W-1:0] chain_upd
);

    localparam int unsigned LANES = BLOCK_W / LANE_W;

    logic [BLOCK_W-1:0] pre_mix;   // plaintext ^ chain (encrypt)
    logic [BLOCK_W-1:0] post_mix;  // result ^ chain (decrypt)

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pre_mix [g*LANE_W +: LANE_W] = in_data [g*LANE_W +: LANE_W] ^ chain_q[g*LANE_W +: LANE_W];
        assign post_mix[g*LANE_W +: LANE_W] = rsp_data[g*LANE_W +: LANE_W] ^ chain_q[g*LANE_W +: LANE_W];
    end

    // Request register; in decrypt it also keeps the consumed ciphertext
    always_ff @(posedge clk) begin
        if (rst)            req_q <= '0;
        else if (take_fire) req_q <= mode_dec ? in_data : pre_mix;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_q <= '0;
        else if (rsp_fire) out_q <= mode_dec ? post_mix : rsp_data;
    end

    // Next chain: produced ciphertext (encrypt) or consumed ciphertext (decrypt)
    assign chain_upd = mode_dec ? req_q : rsp_data;

endmodule

// File: rtl/cbc_chain_unit.sv
module cbc_chain_unit #(
    parameter int unsigned BLOCK_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               iv_load,
    input  logic [BLOCK_W-1:0] iv_data,
    input  logic               cmd_start,
    input  logic               cmd_decrypt,
    input  logic               cmd_continue,
    output logic               cmd_ready,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BLOCK_W-1:0] in_data,
    input  logic               in_last,
    output logic               cph_req_valid,
    input  logic               cph_req_ready,
    output logic [BLOCK_W-1:0] cph_req_data,
    output logic               cph_req_decrypt,
    input  logic               cph_rsp_valid,
    output logic               cph_rsp_ready,
    input  logic [BLOCK_W-1:0] cph_rsp_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [BLOCK_W-1:0] out_data,
    output logic               out_last
);

    logic               start_fire;
    logic               take_fire;
    logic               rsp_fire;
    logic               mode_dec;
    logic [BLOCK_W-1:0] chain_q;
    logic [BLOCK_W-1:0] chain_upd;

    cbc_seq i_seq (
        .clk           (clk),
        .rst           (rst),
        .cmd_start     (cmd_start),
        .cmd_decrypt   (cmd_decrypt),
        .in_valid      (in_valid),
        .in_last       (in_last),
        .cph_req_ready (cph_req_ready),
        .cph_rsp_valid (cph_rsp_valid),
        .out_ready     (out_ready),
        .cmd_ready     (cmd_ready),
        .in_ready      (in_ready),
        .cph_req_valid (cph_req_valid),
        .cph_rsp_ready (cph_rsp_ready),
        .out_valid     (out_valid),
        .out_last      (out_last),
        .start_fire    (start_fire),
        .take_fire     (take_fire),
        .rsp_fire      (rsp_fire),
        .mode_dec      (mode_dec)
    );

    cbc_chain_store #(.BLOCK_W(BLOCK_W)) i_store (
        .clk        (clk),
        .rst        (rst),
        .iv_load    (iv_load),
        .iv_data    (iv_data),
        .start_fire (start_fire),
        .start_cont (cmd_continue),
        .upd_en     (rsp_fire),
        .upd_val    (chain_upd),
        .chain_q    (chain_q)
    );

    cbc_xfer #(.BLOCK_W(BLOCK_W)) i_xfer (
        .clk       (clk),
        .rst       (rst),
        .mode_dec  (mode_dec),
        .take_fire (take_fire),
        .in_data   (in_data),
        .chain_q   (chain_q),
        .rsp_fire  (rsp_fire),
        .rsp_data  (cph_rsp_data),
        .req_q     (cph_req_data),
        .out_q     (out_data),
        .chain_upd (chain_upd)
    );

    assign cph_req_decrypt = mode_dec;

endmodule

// File: rtl/cbc_chain_checker.sv
module cbc_chain_checker #(
    parameter int unsigned BLOCK_W = 128
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_start,
    input logic               cmd_ready,
    input logic               in_valid,
    input logic               in_ready,
    input logic [BLOCK_W-1:0] in_data,
    input logic               cph_req_valid,
    input logic               cph_req_ready,
    input logic [BLOCK_W-1:0] cph_req_data,
    input logic               cph_rsp_valid,
    input logic               cph_rsp_ready,
    input logic [BLOCK_W-1:0] cph_rsp_data,
    input logic               out_valid,
    input logic               out_ready,
    input logic [BLOCK_W-1:0] out_data,
    input logic               out_last,
    input logic               mode_dec
);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> cmd_ready && !in_ready && !cph_req_valid && !out_valid);

    a_r3_enc_out_is_result: assert property (@(posedge clk) disable iff (rst)
        cph_rsp_valid && cph_rsp_ready && !mode_dec |=> out_valid && out_data == $past(cph_rsp_data));

    a_r4_dec_input_passes: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && mode_dec |=> cph_req_valid && cph_req_data == $past(in_data));

    a_r7_out_held: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    a_r7_no_take_during_out: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && in_ready));

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        cph_req_valid && !cph_req_ready |=> cph_req_valid && $stable(cph_req_data));

    a_r9_last_ends_cmd: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> cmd_ready);

    a_r9_idle_exclusive: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !in_ready && !cph_req_valid && !out_valid);

    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        cmd_start && !cmd_ready |=> $stable(mode_dec));

endmodule

bind cbc_chain_unit cbc_chain_checker #(.BLOCK_W(BLOCK_W)) i_checker (
    .clk           (clk),
    .rst           (rst),
    .cmd_start     (cmd_start),
    .cmd_ready     (cmd_ready),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .cph_req_valid (cph_req_valid),
    .cph_req_ready (cph_req_ready),
    .cph_req_data  (cph_req_data),
    .cph_rsp_valid (cph_rsp_valid),
    .cph_rsp_ready (cph_rsp_ready),
    .cph_rsp_data  (cph_rsp_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_last      (out_last),
    .mode_dec      (mode_dec)
);

// File: tb/test_cbc_chain_unit.sv
module test_cbc_chain_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 128;
    localparam int NV         = 8;
    localparam int WATCHDOG   = 150000;
    localparam logic [W-1:0] STUB_KEY = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    localparam logic [W-1:0] IV_MAIN  = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [W-1:0] IV_JUNK  = 128'hdeadbeefdeadbeefdeadbeefdeadbeef;

    // Stimulus table: plaintext, cipher-ready delay, sink stall
    localparam logic [W-1:0] VEC_PT [NV] = '{
        128'h6bc1bee22e409f96e93d7e117393172a,
        128'hae2d8a571e03ac9c9eb76fac45af8e51,
        128'h30c81c46a35ce411e5fbc1191a0a52ef,
        128'hf69f2445df4f9b17ad2b417be66c3710,
        128'h00000000000000000000000000000000,
        128'hffffffffffffffffffffffffffffffff,
        128'h0123456789abcdeffedcba9876543210,
        128'h80000000000000000000000000000001
    };
    localparam int VEC_HOLD  [NV] = '{0, 0, 1, 2, 0, 3, 0, 1};
    localparam int VEC_STALL [NV] = '{0, 2, 0, 1, 3, 0, 1, 0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         iv_load = 1'b0;
    logic [W-1:0] iv_data = '0;
    logic         cmd_start = 1'b0;
    logic         cmd_decrypt = 1'b0;
    logic         cmd_continue = 1'b0;
    logic         cmd_ready;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         cph_req_valid;
    logic         cph_req_ready = 1'b0;
    logic [W-1:0] cph_req_data;
    logic         cph_req_decrypt;
    logic         cph_rsp_valid = 1'b0;
    logic         cph_rsp_ready;
    logic [W-1:0] cph_rsp_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;
    logic         out_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbc_chain_unit #(.BLOCK_W(W)) i_cbc_chain_unit (.*);

    int           n_cmp = 0;
    int           n_bad = 0;
    logic [W-1:0] model_chain = '0;
    logic [W-1:0] model_iv    = '0;
    logic         model_dec   = 1'b0;
    logic [W-1:0] ct_tab [NV];

    // Behavioural stand-in for the cipher core: rotate and key mix
    function automatic logic [W-1:0] stub_enc(input logic [W-1:0] x);
        return {x[W-14:0], x[W-1:W-13]} ^ STUB_KEY;
    endfunction

    function automatic logic [W-1:0] stub_dec(input logic [W-1:0] y);
        logic [W-1:0] t;
        t = y ^ STUB_KEY;
        return {t[12:0], t[W-1:13]};
    endfunction

    task automatic cmp_blk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_iv(input logic [W-1:0] v);
        iv_load = 1'b1;
        iv_data = v;
        tick();
        iv_load = 1'b0;
        model_iv = v;
    endtask

    task automatic start_cmd(input logic dec, input logic cont);
        while (!cmd_ready) tick();
        cmd_start    = 1'b1;
        cmd_decrypt  = dec;
        cmd_continue = cont;
        tick();
        cmd_start = 1'b0;
        model_dec = dec;
        if (!cont) model_chain = model_iv;
    endtask

    task automatic push_block(input logic [W-1:0] data, input logic last,
                              input int hold, input int stall,
                              output logic [W-1:0] got);
        logic [W-1:0] exp_req;
        logic [W-1:0] rsp;
        logic [W-1:0] exp_out;
        logic [W-1:0] snap;
        while (!in_ready) tick();
        in_valid = 1'b1;
        in_data  = data;
        in_last  = last;
        tick();
        in_valid = 1'b0;
        exp_req = model_dec ? data : (data ^ model_chain);
        while (!cph_req_valid) tick();
        for (int k = 0; k < hold; k++) begin
            snap = cph_req_data;
            tick();
            cmp_bit("R8 request valid kept", cph_req_valid, 1'b1);
            cmp_blk("R8 request data kept", cph_req_data, snap);
        end
        if (model_dec) cmp_blk("R4 cipher input", cph_req_data, exp_req);
        else           cmp_blk("R3 cipher input", cph_req_data, exp_req);
        cmp_bit("R4 direction to core", cph_req_decrypt, model_dec);
        cph_req_ready = 1'b1;
        tick();
        cph_req_ready = 1'b0;
        rsp = model_dec ? stub_dec(exp_req) : stub_enc(exp_req);
        tick();
        cph_rsp_valid = 1'b1;
        cph_rsp_data  = rsp;
        while (!cph_rsp_ready) tick();
        tick();
        cph_rsp_valid = 1'b0;
        exp_out     = model_dec ? (rsp ^ model_chain) : rsp;
        model_chain = model_dec ? data : rsp;
        for (int k = 0; k < stall; k++) begin
            tick();
            cmp_bit("R7 output kept valid", out_valid, 1'b1);
            cmp_bit("R7 no input while held", in_ready, 1'b0);
        end
        cmp_bit("R7 output valid", out_valid, 1'b1);
        if (model_dec) cmp_blk("R4 output block", out_data, exp_out);
        else           cmp_blk("R3 output block", out_data, exp_out);
        cmp_bit("R9 last flag", out_last, last);
        got = out_data;
        out_ready = 1'b1;
        tick();
        out_ready = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [W-1:0] got;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_bit("R1 cmd_ready after reset", cmd_ready, 1'b1);
        cmp_bit("R1 in_ready after reset", in_ready, 1'b0);
        cmp_bit("R1 req valid after reset", cph_req_valid, 1'b0);
        cmp_bit("R1 out valid after reset", out_valid, 1'b0);
        start_cmd(1'b0, 1'b1);
        push_block(VEC_PT[0], 1'b1, 0, 0, got);
        cmp_blk("R1 zero chain after reset", got, stub_enc(VEC_PT[0]));

        // R2: latest vector wins
        load_iv(IV_JUNK);
        load_iv(IV_MAIN);
        start_cmd(1'b0, 1'b0);
        push_block(VEC_PT[1], 1'b1, 1, 1, got);
        cmp_blk("R2 latest vector seeds chain", got, stub_enc(VEC_PT[1] ^ IV_MAIN));

        // Table walk: full encrypt, then full decrypt back
        load_iv(IV_MAIN);
        start_cmd(1'b0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            push_block(VEC_PT[i], i == NV-1, VEC_HOLD[i], VEC_STALL[i], got);
            ct_tab[i] = got;
        end
        cmp_bit("R9 idle after last block", cmd_ready, 1'b1);

        load_iv(IV_MAIN);
        start_cmd(1'b1, 1'b0);
        for (int i = 0; i < NV; i++) begin
            push_block(ct_tab[i], i == NV-1, VEC_STALL[i], VEC_HOLD[i], got);
            cmp_blk("R4 decrypt round trip", got, VEC_PT[i]);
        end

        // R5: encryption split over two commands, junk vector between
        load_iv(IV_MAIN);
        start_cmd(1'b0, 1'b0);
        for (int i = 0; i < NV/2; i++) begin
            push_block(VEC_PT[i], i == NV/2-1, 0, 1, got);
            cmp_blk("R5 split encrypt first part", got, ct_tab[i]);
        end
        load_iv(IV_JUNK);
        start_cmd(1'b0, 1'b1);
        for (int i = NV/2; i < NV; i++) begin
            push_block(VEC_PT[i], i == NV-1, 1, 0, got);
            cmp_blk("R5 split encrypt continued", got, ct_tab[i]);
        end

        // R6: decryption split over two commands
        load_iv(IV_MAIN);
        start_cmd(1'b1, 1'b0);
        for (int i = 0; i < NV/2; i++) begin
            push_block(ct_tab[i], i == NV/2-1, 2, 0, got);
            cmp_blk("R6 split decrypt first part", got, VEC_PT[i]);
        end
        load_iv(IV_JUNK);
        start_cmd(1'b1, 1'b1);
        for (int i = NV/2; i < NV; i++) begin
            push_block(ct_tab[i], i == NV-1, 0, 2, got);
            cmp_blk("R6 split decrypt continued", got, VEC_PT[i]);
        end

        // R10: start pulse while busy is ignored
        load_iv(IV_MAIN);
        start_cmd(1'b0, 1'b0);
        load_iv(IV_JUNK);
        cmp_bit("R10 busy before stray start", cmd_ready, 1'b0);
        cmd_start    = 1'b1;
        cmd_decrypt  = 1'b1;
        cmd_continue = 1'b0;
        tick();
        cmd_start = 1'b0;
        push_block(VEC_PT[0], 1'b0, 0, 0, got);
        cmp_blk("R10 stray start kept direction and chain", got, ct_tab[0]);
        push_block(VEC_PT[1], 1'b1, 0, 0, got);
        cmp_blk("R10 chain intact after stray start", got, ct_tab[1]);

        // R1: reset in the middle of a command
        start_cmd(1'b0, 1'b0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        cmp_bit("R1 idle after mid-command reset", cmd_ready, 1'b1);
        model_chain = '0;
        model_iv    = '0;
        start_cmd(1'b0, 1'b1);
        push_block(VEC_PT[2], 1'b1, 0, 0, got);
        cmp_blk("R1 chain cleared by reset", got, stub_enc(VEC_PT[2]));

        report();
        $finish;
    end

endmodule